// File: doc/BRIEF.md
# Pixel Write Normalizer with Nibble Read-Modify-Write

This block sits between a pixel or texel producer and a 32-bit word-addressed memory that has a byte-enable per lane. The producer issues write requests with a natural byte address, a 6-bit format code, a payload justified to the least significant bits and, for 4-bit pixels, a nibble select. The block turns each request into a word-aligned memory write. The payload is shifted into the lane or lanes that the address selects, and a matching byte-enable mask is set. Malformed or unknown requests are turned into dropped writes.

A 4-bit pixel covers only half a byte, so the block reads the target word first. It takes the addressed byte from the returned word and replaces the selected nibble. It then writes the merged byte back as a single-lane write, which keeps the other nibble intact. The memory port is synchronous, and read data appears one cycle after the read strobe. The block never issues a read and a write in the same cycle. A request that follows a 4-bit write therefore sees the finished write.

The request side uses valid/ready. A requester that sees `req_valid` high and `req_ready` low must hold every request field stable until the handshake completes. `req_ready` is high whenever the block is idle, except while the block is accepting a 4-bit request. A 4-bit request spends its first cycle on the read with `req_ready` low. It completes with `req_ready` high in the next cycle, which is the write cycle.

Top module: `pxw_norm`

## Requirements
- R1: Every memory access (read or write) uses the request byte address with bits [1:0] cleared.
- R2: Format 0x00 (32-bit colour) at an address with bits [1:0] = 0 writes the whole payload with byte enables 1111. At any other alignment the write is dropped: no write strobe, enables 0000, data 0.
- R3: Format 0x02 (16-bit colour) with address bit 0 set is dropped. With address bit 1 = 0, payload[15:0] goes to data[15:0] with enables 0011. With address bit 1 = 1, it goes to data[31:16] with enables 1100. All other data bits are 0.
- R4: Format 0x13 (8-bit index) accepts any byte address. Lane L = address[1:0] receives payload[7:0] in data[8L+7:8L], enable bit L alone is set, and the other data bits are 0.
- R5: Format 0x14 (4-bit index) first reads the target word. It then writes one lane, lane L = address[1:0], with a merged byte. The merged byte is {payload[3:0], old[3:0]} when the nibble select is 1 and {old[7:4], payload[3:0]} when it is 0, where old is byte L of the read word.
- R6: Any other format code produces no memory access (write and read strobes low, enables 0000, data 0) and completes in one cycle.
- R7: Formats 0x00, 0x02 and 0x13, and dropped requests, complete in the cycle they are presented, with `req_ready` high. A 4-bit request holds `req_ready` low during its read cycle and completes in the following write cycle. A write always follows its read by exactly one cycle.
- R8: A request that follows a 4-bit write observes that write. Consecutive 4-bit writes to both nibbles of one byte leave both new nibbles in memory.
- R9: After reset with no request pending, `req_ready` is high and both memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Natural byte address |
| req_fmt | input | 6 | Pixel format code |
| req_data | input | 32 | LSB-justified payload |
| req_nib_hi | input | 1 | 4-bit formats: 1 selects the upper nibble |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-shifted write data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |

## Verification
The bench targets misaligned 32-bit and 16-bit requests and unknown format codes. A design that mishandled these would still strobe a write, leave stray data bits set, or take the wrong number of cycles. It writes both nibbles of one byte back to back, and mixes 4-bit writes into the same word as 8-bit and 16-bit writes. A design that registered read data too early or too late, picked the wrong read lane, or swapped the nibble halves would leave memory different from the byte-array reference. Every lane of every format is checked for the enable mask and data placement. A design that mixed up lanes, or did not zero the unused bits, would fail these checks at once.

// File: rtl/pxw_pkg.sv
package pxw_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = WORD_W / 8;
  localparam int LANE_W  = $clog2(LANES);

  localparam logic [5:0] FMT_C32 = 6'h00;
  localparam logic [5:0] FMT_C16 = 6'h02;
  localparam logic [5:0] FMT_I8  = 6'h13;
  localparam logic [5:0] FMT_I4  = 6'h14;

  typedef enum logic [1:0] {
    K_DROP  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } pxw_kind_e;

  typedef enum logic {
    S_IDLE  = 1'b0,
    S_MERGE = 1'b1
  } pxw_state_e;
endpackage

// File: rtl/pxw_nib_merge.sv
module pxw_nib_merge
  import pxw_pkg::*;
(
  input  logic [WORD_W-1:0] rd_word,
  input  logic [LANE_W-1:0] lane,
  input  logic              hi_sel,
  input  logic [3:0]        nibble,
  output logic [7:0]        merged
);
  logic [7:0] old_byte;

  always_comb begin
    old_byte = rd_word[8*lane +: 8];
    if (hi_sel) merged = {nibble, old_byte[3:0]};
    else        merged = {old_byte[7:4], nibble};
  end
endmodule

// File: rtl/pxw_decode.sv
module pxw_decode
  import pxw_pkg::*;
(
  input  logic [5:0]        fmt,
  input  logic [LANE_W-1:0] addr_lo,
  input  logic [WORD_W-1:0] payload,
  input  logic [7:0]        merged,
  output pxw_kind_e         kind,
  output logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  be
);
  logic [7:0]        byte_val;
  logic [WORD_W-1:0] byte_rep;
  logic [LANES-1:0]  lane_hot;

  assign byte_val = (fmt == FMT_I4) ? merged : payload[7:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_rep[8*g +: 8] = byte_val;
    assign lane_hot[g]        = (addr_lo == LANE_W'(g));
  end

  always_comb begin
    kind = K_DROP;
    data = '0;
    be   = '0;
    unique case (fmt)
      FMT_C32: begin
        if (addr_lo == '0) begin
          kind = K_WRITE;
          data = payload;
          be   = '1;
        end
      end
      FMT_C16: begin
        if (!addr_lo[0]) begin
          kind = K_WRITE;
          if (addr_lo[1]) begin
            data = {payload[15:0], 16'd0};
            be   = 4'b1100;
          end else begin
            data = {16'd0, payload[15:0]};
            be   = 4'b0011;
          end
        end
      end
      FMT_I8, FMT_I4: begin
        kind = (fmt == FMT_I4) ? K_READ : K_WRITE;
        be   = lane_hot;
        for (int i = 0; i < LANES; i++)
          data[8*i +: 8] = lane_hot[i] ? byte_rep[8*i +: 8] : 8'd0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pxw_norm.sv
module pxw_norm
  import pxw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [5:0]        req_fmt,
  input  logic [31:0]       req_data,
  input  logic              req_nib_hi,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  pxw_state_e        state, state_nx;
  logic [ADDR_W-1:0] hold_addr;
  logic [3:0]        hold_nib;
  logic              hold_hi;

  logic [ADDR_W-1:0] cur_addr;
  logic [5:0]        cur_fmt;
  logic [WORD_W-1:0] cur_payload;
  logic [7:0]        merged;
  pxw_kind_e         kind;
  logic [WORD_W-1:0] dec_data;
  logic [LANES-1:0]  dec_be;
  logic              in_merge;

  assign in_merge    = (state == S_MERGE);
  assign cur_addr    = in_merge ? hold_addr : req_addr;
  assign cur_fmt     = in_merge ? FMT_I4 : req_fmt;
  assign cur_payload = in_merge ? {28'd0, hold_nib} : req_data;

  pxw_nib_merge u_merge (
    .rd_word (mem_rdata),
    .lane    (hold_addr[LANE_W-1:0]),
    .hi_sel  (hold_hi),
    .nibble  (hold_nib),
    .merged  (merged)
  );

  pxw_decode u_dec (
    .fmt     (cur_fmt),
    .addr_lo (cur_addr[LANE_W-1:0]),
    .payload (cur_payload),
    .merged  (merged),
    .kind    (kind),
    .data    (dec_data),
    .be      (dec_be)
  );

  always_comb begin
    state_nx  = state;
    req_ready = 1'b1;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    if (in_merge) begin
      mem_we   = 1'b1;
      state_nx = S_IDLE;
    end else if (req_valid) begin
      unique case (kind)
        K_READ: begin
          mem_re    = 1'b1;
          req_ready = 1'b0;
          state_nx  = S_MERGE;
        end
        K_WRITE: mem_we = 1'b1;
        default: ;
      endcase
    end
  end

  assign mem_addr  = {cur_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign mem_be    = mem_we ? dec_be : '0;
  assign mem_wdata = mem_we ? dec_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      hold_addr <= '0;
      hold_nib  <= '0;
      hold_hi   <= 1'b0;
    end else begin
      state <= state_nx;
      if (mem_re) begin
        hold_addr <= req_addr;
        hold_nib  <= req_data[3:0];
        hold_hi   <= req_nib_hi;
      end
    end
  end
endmodule

// File: rtl/pxw_norm_chk.sv
module pxw_norm_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be
);
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr[1:0] == 2'b00));

  assert_read_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !req_ready);

  assert_write_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> mem_we);

  assert_merge_single_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_re) && mem_we) |-> ($countones(mem_be) == 1));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_write_has_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != 4'b0000));
endmodule

bind pxw_norm pxw_norm_chk #(.ADDR_W(ADDR_W)) u_pxw_norm_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be)
);

// File: tb/test_pxw_norm.sv
`timescale 1ns/1ps
module test_pxw_norm;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [5:0]    req_fmt = '0;
  logic [31:0]   req_data = '0;
  logic          req_nib_hi = 1'b0;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata;
  logic [31:0]   mem_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0]  refm [0:255];
  logic [31:0] bmem [0:63];

  always #2 clk = ~clk;

  pxw_norm #(.ADDR_W(AW)) i_pxw_norm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_fmt(req_fmt), .req_data(req_data),
    .req_nib_hi(req_nib_hi), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bmem[i] <= 32'd0;
      mem_rdata <= 32'd0;
    end else begin
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      if (mem_re) mem_rdata <= bmem[mem_addr[7:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] f);
    case (f)
      6'h00: return "R2";
      6'h02: return "R3";
      6'h13: return "R4";
      6'h14: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Expected enable mask / data for single-cycle formats, from R2/R3/R4/R6
  function automatic logic [35:0] expect_word(input logic [7:0] a, input logic [5:0] f,
                                              input logic [31:0] d);
    logic [3:0]  e;
    logic [31:0] w;
    e = 4'b0; w = 32'd0;
    if (f == 6'h00 && a[1:0] == 2'd0) begin e = 4'hF; w = d; end
    else if (f == 6'h02 && !a[0]) begin
      e = a[1] ? 4'b1100 : 4'b0011;
      w = a[1] ? {d[15:0], 16'h0} : {16'h0, d[15:0]};
    end else if (f == 6'h13) begin
      e = 4'b0001 << a[1:0];
      w = {24'h0, d[7:0]} << (8 * a[1:0]);
    end
    return {e, w};
  endfunction

  task automatic send(input logic [7:0] a, input logic [5:0] f,
                      input logic [31:0] d, input logic hi);
    logic [35:0] ew;
    logic [7:0]  nb;
    string       t;
    t = tag_of(f);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {24'd0, a}; req_fmt = f;
    req_data = d; req_nib_hi = hi;
    #1;
    if (f != 6'h14) begin
      ew = expect_word(a, f, d);
      chk(req_ready == 1'b1, "R7", "one-cycle ready", {31'd0, req_ready}, 32'd1);
      if (ew[35:32] != 4'd0) begin
        chk(mem_we == 1'b1 && mem_re == 1'b0, t, "write strobe", {30'd0, mem_we, mem_re}, 32'd2);
        chk(mem_addr == {24'd0, a[7:2], 2'b00}, "R1", "aligned addr", mem_addr, {24'd0, a[7:2], 2'b00});
        chk(mem_be == ew[35:32], t, "byte enables", {28'd0, mem_be}, {28'd0, ew[35:32]});
        chk(mem_wdata == ew[31:0], t, "write data", mem_wdata, ew[31:0]);
        for (int b = 0; b < 4; b++) if (ew[32+b]) refm[{a[7:2], 2'(b)}] = ew[8*b +: 8];
      end else begin
        chk(mem_we == 1'b0 && mem_re == 1'b0, t, "dropped: no access", {30'd0, mem_we, mem_re}, 32'd0);
        chk(mem_be == 4'd0 && mem_wdata == 32'd0, t, "dropped: zero be/data", mem_wdata | {28'd0, mem_be}, 32'd0);
      end
      @(posedge clk);
    end else begin
      chk(req_ready == 1'b0, "R7", "ready low in read cycle", {31'd0, req_ready}, 32'd0);
      chk(mem_re == 1'b1 && mem_we == 1'b0, "R5", "read strobe", {30'd0, mem_we, mem_re}, 32'd1);
      chk(mem_addr == {24'd0, a[7:2], 2'b00}, "R1", "aligned read addr", mem_addr, {24'd0, a[7:2], 2'b00});
      @(posedge clk);
      @(negedge clk);
      #1;
      nb = hi ? {d[3:0], refm[a][3:0]} : {refm[a][7:4], d[3:0]};
      chk(req_ready == 1'b1, "R7", "ready in write cycle", {31'd0, req_ready}, 32'd1);
      chk(mem_we == 1'b1 && mem_be == (4'b0001 << a[1:0]), "R5", "merge write lane",
          {27'd0, mem_we, mem_be}, {27'd0, 1'b1, 4'b0001 << a[1:0]});
      chk(mem_wdata == ({24'd0, nb} << (8 * a[1:0])), "R8", "merged byte data",
          mem_wdata, {24'd0, nb} << (8 * a[1:0]));
      refm[a] = nb;
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic compare_mem();
    for (int i = 0; i < 256; i++)
      chk(bmem[i/4][8*(i%4) +: 8] == refm[i], "R8", $sformatf("memory byte %0d", i),
          {24'd0, bmem[i/4][8*(i%4) +: 8]}, {24'd0, refm[i]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) refm[i] = 8'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready == 1'b1 && mem_we == 1'b0 && mem_re == 1'b0, "R9", "reset state",
        {29'd0, req_ready, mem_we, mem_re}, 32'd4);
    // Directed: every lane of every format
    for (int l = 0; l < 4; l++) begin
      send(8'd16 + 8'(l), 6'h00, 32'hA1B2C3D4, 1'b0);
      send(8'd32 + 8'(l), 6'h02, 32'hFFFF5A6B, 1'b0);
      send(8'd48 + 8'(l), 6'h13, 32'hFFFFFF80 + 32'(l), 1'b0);
      send(8'd64 + 8'(l), 6'h14, 32'h9, 1'b0);
      send(8'd64 + 8'(l), 6'h14, 32'h6, 1'b1);
    end
    send(8'd80, 6'h3F, 32'hDEADBEEF, 1'b0);
    send(8'd84, 6'h01, 32'h12345678, 1'b1);
    // R8: 4-bit write then byte/halfword/4-bit in same word
    send(8'd100, 6'h13, 32'h5C, 1'b0);
    send(8'd100, 6'h14, 32'h3, 1'b1);
    send(8'd100, 6'h14, 32'hE, 1'b0);
    send(8'd102, 6'h02, 32'h7788, 1'b0);
    send(8'd103, 6'h14, 32'h1, 1'b1);
    compare_mem();
    // Constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 400; n++) begin
      logic [5:0] f;
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1: f = 6'h00;
        2, 3: f = 6'h02;
        4, 5: f = 6'h13;
        6, 7, 8: f = 6'h14;
        default: f = 6'($urandom_range(0, 63));
      endcase
      send(8'($urandom_range(0, 255)), f, $urandom, 1'($urandom_range(0, 1)));
    end
    compare_mem();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule